// File: doc/BRIEF.md
# Lockable VCO Post-Divider

This block derives a slower clock from a fast oscillator clock by dividing it by a programmable ratio between 1 and 8. Software programs a small divide code and an output enable through a single write strobe. The divide code can only change while the output is switched off. A locked code keeps a running clock from changing frequency or glitching when a stray write arrives. The current code and enable can always be read back.

The output aims for an even split between high and low time. Even ratios always give an exact 50% duty. Odd ratios depend on a range input that tells the block which oscillator band feeds it. In the high band the block adds half a cycle of high time with a falling-edge stage, so odd ratios also reach 50%. In the low band an odd ratio is allowed an uneven split. Code zero routes the input clock straight to the output.

Top module: `vco_postdiv`

## Requirements
- R1: After reset the divide code reads 1, so the ratio is 2. The enable reads 0 and the output clock is low.
- R2: A 3-bit code N sets a ratio of N+1 input cycles per output period, for N from 1 to 7. The period counter returns to its start after N+1 cycles.
- R3: Code 0 passes the input clock to the output undivided while the enable is 1.
- R4: For an even ratio N+1, in either range, the output is high for the first (N+1)/2 input cycles of each period and low for the rest.
- R5: With the range input at 0 (low band) and an odd ratio N+1, the output is high for floor((N+1)/2) input cycles and low for the remaining cycles of the period.
- R6: With the range input at 1 (high band) and an odd ratio N+1 of at least 3, the output is high for (N+1)/2 input cycles, including a half cycle, and low for the same time.
- R7: A write strobe always loads the enable bit from its data. It loads the divide code from its data only if the enable bit held before that strobe is 0. Both take effect at the clock edge that samples the strobe.
- R8: A write strobe that arrives while the enable is 1 leaves the divide code unchanged. The read-back port and the output waveform show no change.
- R9: While the enable is 0 the output is held low. The enable takes effect at the edge that samples the write. From that edge the output begins the high part of a fresh period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_vco_i | input | 1 | Fast oscillator clock; also clocks the configuration register |
| rst_ni | input | 1 | Synchronous active-low reset |
| range_hi_i | input | 1 | Oscillator band: 1 = high band (odd ratios at 50%), 0 = low band |
| wr_i | input | 1 | Configuration write strobe, one cycle |
| wr_code_i | input | CODE_W | Divide code to load (ratio = code + 1) |
| wr_ena_i | input | 1 | Output enable value to load |
| rd_code_o | output | CODE_W | Current divide code |
| rd_ena_o | output | 1 | Current output enable |
| clk_div_o | output | 1 | Divided output clock |

## Verification
The bench builds the block with its default parameters: a 3-bit code, reset code 1 and the half-cycle stage present. With a 3-bit code, all eight codes and both band settings can be covered in a short run. The scoreboard checks the output at every half input cycle. This resolves the half-cycle stretch in the high band and the bypass of code 0. A locked write is issued in the middle of a running period, so both the read-back port and the waveform show that it was ignored.

// File: rtl/postdiv_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the post-divider.
// Assumes: nothing beyond the standard language.
package postdiv_pkg;

    // Oscillator band selector as seen by the shaping stage
    typedef enum logic {
        BAND_LOW  = 1'b0,
        BAND_HIGH = 1'b1
    } band_e;

endpackage

// File: rtl/postdiv_cfg.sv
`timescale 1ns/1ps
// Module: postdiv_cfg
// Holds the divide code and the output enable. The enable loads on every
// strobe. The code loads only while the enable held before the strobe is 0.
// Assumes: the strobe is synchronous to clk_i and lasts one cycle.
module postdiv_cfg #(
    parameter int CODE_W   = 3,
    parameter int RST_CODE = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [CODE_W-1:0] wr_code_i,
    input  logic              wr_ena_i,
    output logic [CODE_W-1:0] code_o,
    output logic              ena_o
);

    localparam logic [CODE_W-1:0] CodeInit = CODE_W'(RST_CODE);

    logic [CODE_W-1:0] code_q;
    logic              ena_q;
    logic              code_open;

    // A code write is accepted only while the output is stopped
    always_comb begin
        code_open = wr_i && !ena_q;
    end

    // Register the code under the lock rule
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            code_q <= CodeInit;
        end else if (code_open) begin
            code_q <= wr_code_i;
        end
    end

    // Register the enable on every strobe
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ena_q <= 1'b0;
        end else if (wr_i) begin
            ena_q <= wr_ena_i;
        end
    end

    assign code_o = code_q;
    assign ena_o  = ena_q;

endmodule

// File: rtl/postdiv_phase.sv
`timescale 1ns/1ps
// Module: postdiv_phase
// Counts input cycles modulo (code+1). It raises a rising-edge phase for the
// first floor((code+1)/2) cycles of each period. The count is held at 0 while
// disabled, so an enable always starts a fresh period.
// Assumes: the code does not change while ena_i is 1.
module postdiv_phase #(
    parameter int CODE_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ena_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] cnt_o,
    output logic              phase_o
);

    localparam int RW = CODE_W + 1;

    logic [CODE_W-1:0] cnt_q;
    logic [RW-1:0]     ratio;
    logic [RW-1:0]     high_len;
    logic              at_end;

    // Derive the ratio, the length of the high part, and the period end
    always_comb begin
        ratio    = {1'b0, code_i} + RW'(1);
        high_len = ratio >> 1;
        at_end   = (cnt_q == code_i);
    end

    // Advance the period counter, or hold it at the start while stopped
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (!ena_i || at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CODE_W'(1);
        end
    end

    // The rising-edge phase is high in the first part of the period
    always_comb begin
        phase_o = ena_i && ({1'b0, cnt_q} < high_len);
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/postdiv_shape.sv
`timescale 1ns/1ps
// Module: postdiv_shape
// Forms the output clock. It selects among three sources:
// - the bypassed input (code 0);
// - the rising-edge phase alone (even ratios, or odd ratios in the low band);
// - the phase ORed with a copy delayed by half a cycle (odd ratios in the
//   high band).
// HALF_EN = 0 removes the falling-edge stage.
// Assumes: code and band are steady while the enable is 1.
module postdiv_shape
    import postdiv_pkg::*;
#(
    parameter int CODE_W  = 3,
    parameter bit HALF_EN = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ena_i,
    input  logic [CODE_W-1:0] code_i,
    input  band_e             band_i,
    input  logic              phase_i,
    output logic              clk_o
);

    logic phase_late;
    logic bypass;
    logic odd_ratio;
    logic stretch;

    generate
        if (HALF_EN) begin : g_half
            logic late_q;
            // Copy the phase at the falling edge to add half a cycle of high time
            always_ff @(negedge clk_i) begin
                if (!rst_ni) begin
                    late_q <= 1'b0;
                end else begin
                    late_q <= phase_i;
                end
            end
            assign phase_late = late_q && ena_i;
        end else begin : g_nohalf
            assign phase_late = 1'b0;
        end
    endgenerate

    // Decide the source from the code and the band
    always_comb begin
        bypass    = (code_i == '0);
        odd_ratio = !code_i[0];
        stretch   = odd_ratio && (band_i == BAND_HIGH);
    end

    // Drive the output clock from the selected source
    always_comb begin
        if (bypass) begin
            clk_o = clk_i && ena_i;
        end else if (stretch) begin
            clk_o = phase_i || phase_late;
        end else begin
            clk_o = phase_i;
        end
    end

endmodule

// File: rtl/vco_postdiv.sv
`timescale 1ns/1ps
// Module: vco_postdiv (top)
// Programmable post-divider for a fast oscillator clock with a write lock.
// It joins the configuration register, the period counter and the output
// shaper.
// Assumes: the write port and the oscillator share clk_vco_i.
module vco_postdiv
    import postdiv_pkg::*;
#(
    parameter int CODE_W   = 3,
    parameter int RST_CODE = 1,
    parameter bit HALF_EN  = 1'b1
) (
    input  logic              clk_vco_i,
    input  logic              rst_ni,
    input  logic              range_hi_i,
    input  logic              wr_i,
    input  logic [CODE_W-1:0] wr_code_i,
    input  logic              wr_ena_i,
    output logic [CODE_W-1:0] rd_code_o,
    output logic              rd_ena_o,
    output logic              clk_div_o
);

    logic [CODE_W-1:0] cfg_code;
    logic              cfg_ena;
    logic [CODE_W-1:0] cnt_q;
    logic              phase;
    band_e             band;

    // Map the band pin onto the package type
    always_comb begin
        band = range_hi_i ? BAND_HIGH : BAND_LOW;
    end

    postdiv_cfg #(
        .CODE_W   (CODE_W),
        .RST_CODE (RST_CODE)
    ) cfg_i (
        .clk_i     (clk_vco_i),
        .rst_ni    (rst_ni),
        .wr_i      (wr_i),
        .wr_code_i (wr_code_i),
        .wr_ena_i  (wr_ena_i),
        .code_o    (cfg_code),
        .ena_o     (cfg_ena)
    );

    postdiv_phase #(
        .CODE_W (CODE_W)
    ) phase_i (
        .clk_i   (clk_vco_i),
        .rst_ni  (rst_ni),
        .ena_i   (cfg_ena),
        .code_i  (cfg_code),
        .cnt_o   (cnt_q),
        .phase_o (phase)
    );

    postdiv_shape #(
        .CODE_W  (CODE_W),
        .HALF_EN (HALF_EN)
    ) shape_i (
        .clk_i   (clk_vco_i),
        .rst_ni  (rst_ni),
        .ena_i   (cfg_ena),
        .code_i  (cfg_code),
        .band_i  (band),
        .phase_i (phase),
        .clk_o   (clk_div_o)
    );

    assign rd_code_o = cfg_code;
    assign rd_ena_o  = cfg_ena;

endmodule

// File: rtl/postdiv_chk.sv
`timescale 1ns/1ps
// Module: postdiv_chk
// Checker bound into vco_postdiv. It watches the register rules, the period
// counter and the idle output.
// Assumes: connected through the bind statement below.
module postdiv_chk #(
    parameter int CODE_W   = 3,
    parameter int RST_CODE = 1
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_i,
    input logic [CODE_W-1:0] wr_code_i,
    input logic [CODE_W-1:0] code_i,
    input logic              ena_i,
    input logic [CODE_W-1:0] cnt_i,
    input logic              clk_out_i
);

    // Reset loads the default code and clears the enable
    assert_reset_value_R1: assert property (@(posedge clk_i)
        !rst_ni |=> (code_i == CODE_W'(RST_CODE) && !ena_i));

    // The counter returns to the start once a period is complete
    assert_period_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ena_i && cnt_i == code_i) |=> (cnt_i == '0));

    // Within a period the counter advances by one per cycle
    assert_period_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ena_i && cnt_i != code_i) |=> (cnt_i == $past(cnt_i) + CODE_W'(1)));

    // A write made while stopped loads the code
    assert_open_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !ena_i) |=> (code_i == $past(wr_code_i)));

    // A write made while running leaves the code unchanged
    assert_locked_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && ena_i) |=> (code_i == $past(code_i)));

    // An enable starts at the beginning of a period
    assert_clean_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ena_i) |-> (cnt_i == '0));

    // The output stays low while stopped
    assert_idle_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ena_i |-> !clk_out_i);

endmodule

bind vco_postdiv postdiv_chk #(
    .CODE_W   (CODE_W),
    .RST_CODE (RST_CODE)
) chk_i (
    .clk_i     (clk_vco_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wr_code_i (wr_code_i),
    .code_i    (cfg_code),
    .ena_i     (cfg_ena),
    .cnt_i     (cnt_q),
    .clk_out_i (clk_div_o)
);

// File: tb/vco_postdiv_tb_top.sv
`timescale 1ns/1ps
// Bench: scoreboard of half-cycle samples of the output clock.
module vco_postdiv_tb_top;

    localparam int CW = 3;

    typedef struct {
        bit    val;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          range_hi = 1'b0;
    logic          wr = 1'b0;
    logic [CW-1:0] wr_code = '0;
    logic          wr_ena = 1'b0;
    logic [CW-1:0] rd_code;
    logic          rd_ena;
    logic          clk_div;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    vco_postdiv #(.CODE_W(CW)) dut_i (
        .clk_vco_i  (clk),
        .rst_ni     (rst_n),
        .range_hi_i (range_hi),
        .wr_i       (wr),
        .wr_code_i  (wr_code),
        .wr_ena_i   (wr_ena),
        .rd_code_o  (rd_code),
        .rd_ena_o   (rd_ena),
        .clk_div_o  (clk_div)
    );

    // Expected output in half-cycle j after the enabling edge
    function automatic bit exp_bit(int code, bit hi, int j);
        int  ratio = code + 1;
        int  c = j / 2;
        int  s = j % 2;
        int  hl = ratio / 2;
        bit  p_now;
        bit  p_prev;
        if (code == 0) return (s == 0);
        p_now  = ((c % ratio) < hl);
        p_prev = (c > 0) ? (((c - 1) % ratio) < hl) : 1'b0;
        if (hi && (ratio % 2 == 1)) return p_now | (s == 1 ? p_now : p_prev);
        return p_now;
    endfunction

    function automatic string tag_for(int code, bit hi);
        if (code == 0) return "R3";
        if ((code + 1) % 2 == 0) return "R2/R4";
        if (hi) return "R2/R6";
        return "R2/R5";
    endfunction

    task automatic check_val(string tag, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Monitor: compare one queued item in each half cycle
    task automatic sample_out();
        exp_t e;
        if (exp_q.size() != 0) begin
            e = exp_q.pop_front();
            check_val(e.tag, int'(clk_div), int'(e.val));
        end
    endtask

    always @(posedge clk) begin
        #1;
        sample_out();
    end

    always @(negedge clk) begin
        #1;
        sample_out();
    end

    // Driver: issue a strobe, then queue the expected output for ncyc cycles
    task automatic write_cfg(int code, bit ena, bit hi, int ncyc, int run_code);
        exp_t e;
        @(posedge clk);
        #2;
        wr       = 1'b1;
        wr_code  = CW'(code);
        wr_ena   = ena;
        range_hi = hi;
        @(posedge clk);
        for (int j = 0; j < 2 * ncyc; j++) begin
            e.val = ena ? exp_bit(run_code, hi, j) : 1'b0;
            e.tag = ena ? tag_for(run_code, hi) : "R9";
            exp_q.push_back(e);
        end
        #2;
        wr = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
    endtask

    // Run one stopped-program-run-stop case
    task automatic run_case(int code, bit hi, int ncyc);
        write_cfg(code, 1'b0, hi, 0, code);
        #1;
        check_val("R7 code", int'(rd_code), code);
        write_cfg(code, 1'b1, hi, ncyc, code);
        #1;
        check_val("R7 ena", int'(rd_ena), 1);
        drain();
        write_cfg(code, 1'b0, hi, 3, code);
        drain();
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_val("R1 code", int'(rd_code), 1);
        check_val("R1 ena", int'(rd_ena), 0);
        check_val("R1 out", int'(clk_div), 0);
        @(negedge clk);
        #1;
        check_val("R1 out low half", int'(clk_div), 0);

        // Default code enabled without reprogramming: ratio 2
        write_cfg(1, 1'b1, 1'b0, 8, 1);
        drain();
        write_cfg(1, 1'b0, 1'b0, 2, 1);
        drain();

        // Ratio 4, with a locked write in the middle of the run
        write_cfg(3, 1'b0, 1'b0, 0, 3);
        write_cfg(3, 1'b1, 1'b0, 16, 3);
        repeat (3) @(posedge clk);
        write_cfg(6, 1'b1, 1'b0, 0, 3);
        #1;
        check_val("R8 code kept", int'(rd_code), 3);
        drain();
        check_val("R8 code kept after run", int'(rd_code), 3);
        write_cfg(3, 1'b0, 1'b0, 3, 3);
        drain();

        run_case(2, 1'b0, 12);
        run_case(2, 1'b1, 12);
        run_case(4, 1'b1, 15);
        run_case(6, 1'b0, 14);
        run_case(6, 1'b1, 14);
        run_case(7, 1'b1, 16);
        run_case(5, 1'b0, 12);
        run_case(1, 1'b1, 8);
        run_case(0, 1'b0, 6);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule